// File: doc/BRIEF.md
# Converter Host Bus Interface

This block sits between a processor-style parallel bus and a converter core that produces a 10-bit result plus an out-of-range flag. It synchronizes the active-low select, write and read strobes and the static straps to its clock. From them it starts conversions on the core, reports conversion progress on a busy line, and presents the latest result either as one 11-bit word or as two bytes. The data and busy outputs come with separate output-enable ports, so the pad ring can build the tri-state drivers.

A mode strap chooses between two families of operation. With the strap high, the host starts single conversions by selecting the block and pulsing write. If select, read and write are all held low, the block instead converts back to back for hardware capture. With the strap low, the block converts continuously whenever write is low. In that mode a high-byte read locks the result register until the matching low-byte read has finished, so that the two bytes of one read always come from the same conversion.

The conversion engine itself is outside the block. It sees a one-cycle start pulse and answers with a done pulse that carries the result.

Top module: `adc_host_port`

## Requirements
- R1: With slow_strap high, a conversion starts only while cs_n and wr_n are both low. conv_start is a single-cycle pulse that first appears 2 clock cycles after the strobes fall. A write pulse shorter than one conversion starts exactly one conversion, and wr_n low with cs_n high starts none.
- R2: busy is 0 from the cycle after conv_start until the cycle after the accepted conv_done, and 1 otherwise. busy_oe is 0 exactly when cs_n and rd_n are both high (after synchronization).
- R3: With wide_bus high, cs_n and rd_n low raise both oe_lo and oe_hi. dout[9:0] carries the result and dout[10] carries the out-of-range flag.
- R4: With wide_bus low, byte_hi high raises only oe_hi, which covers dout[10:8], and byte_hi low raises only oe_lo, which covers dout[7:0]. With rd_n high, neither enable is raised.
- R5: With slow_strap low, conversions run back to back whenever wr_n is low, whatever cs_n is. cs_n high only blocks reads, so no enable is raised.
- R6: With slow_strap low and wide_bus low, the start of a read with byte_hi high freezes dout until a read with byte_hi low has ended. Results completed while dout is frozen are dropped, and dout is stable for the whole frozen interval.
- R7: With slow_strap high and cs_n, rd_n and wr_n all low, conversions run back to back and busy stays 0. With slow_strap low, busy is also 0 while a read is active.
- R8: When dout is not frozen, every accepted conv_done loads dout on the next clock edge, so a host holding rd_n low sees each new result.
- R9: In slow and hardwired modes, reading the high byte never freezes dout, so the bytes may be read in either order and later results still load.
- R10: A conv_done that arrives when no conversion is in progress changes neither dout nor busy.
- R11: After reset, conv_start, busy_oe, oe_lo and oe_hi are 0 and dout is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low select strobe |
| wr_n | input | 1 | Active-low write / conversion request strobe |
| rd_n | input | 1 | Active-low read strobe |
| slow_strap | input | 1 | High: host-started or hardwired mode; low: free-running locked-read mode |
| wide_bus | input | 1 | High: whole 11-bit word per read; low: byte reads |
| byte_hi | input | 1 | In byte reads, high selects dout[10:8], low selects dout[7:0] |
| conv_start | output | 1 | One-cycle request to the conversion engine |
| conv_done | input | 1 | One-cycle completion pulse from the engine |
| conv_data | input | DATA_W | Result delivered with conv_done |
| conv_ovr | input | 1 | Out-of-range flag delivered with conv_done |
| busy | output | 1 | Low while converting (and in the cases of R7) |
| busy_oe | output | 1 | Drive enable for busy |
| dout | output | DATA_W+1 | Result register: flag in the top bit |
| oe_lo | output | 1 | Drive enable for dout[7:0] |
| oe_hi | output | 1 | Drive enable for dout[10:8] |

## Verification
An active flag stuck high shows up as busy staying low and no further conv_start. An active flag stuck low shows up as a second start pulse on the cycle after the first. Both can be seen within one conversion. A freeze flag that is set wrongly or released too early shows up at the next conv_done: dout holds when it should update, or changes between the two byte reads. The directed scenarios therefore sample dout across several conversions on both sides of each freeze edge, and check the start pulse at its exact cycle.

// File: rtl/ahp_pkg.sv
package ahp_pkg;

  typedef enum logic [1:0] {
    AHP_SLOW = 2'd0,
    AHP_FAST = 2'd1,
    AHP_DMA  = 2'd2
  } ahp_mode_e;

  // Operating mode inferred from the strap and the (synchronized, active-high) strobes.
  function automatic ahp_mode_e ahp_decode(input logic slow_strap, input logic cs_a,
                                           input logic rd_a, input logic wr_a);
    if (!slow_strap) return AHP_FAST;
    if (cs_a && rd_a && wr_a) return AHP_DMA;
    return AHP_SLOW;
  endfunction

endpackage

// File: rtl/ahp_sync.sv
module ahp_sync #(
  parameter int WIDTH = 6,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= RST_VAL;
        else        stg_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= RST_VAL;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/ahp_conv_seq.sv
module ahp_conv_seq
  import ahp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  ahp_mode_e mode,
  input  logic      cs_a,
  input  logic      wr_a,
  input  logic      rd_a,
  input  logic      conv_done,
  output logic      conv_start,
  output logic      active,
  output logic      busy_val,
  output logic      busy_oe
);

  logic active_q, active_d, trig;

  // Next-state
  always_comb begin
    trig       = (mode == AHP_FAST) ? wr_a : (cs_a & wr_a);
    conv_start = ~active_q & trig;
    active_d   = active_q;
    if (active_q && conv_done) active_d = 1'b0;
    if (conv_start)            active_d = 1'b1;
  end

  // Register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= active_d;
  end

  assign active   = active_q;
  assign busy_val = ~active_q & ~(cs_a & rd_a & (mode != AHP_SLOW));
  assign busy_oe  = cs_a | rd_a;

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R1
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !busy_val); // R2
  AST_DMA_BUSY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == AHP_DMA) |-> !busy_val); // R7

endmodule

// File: rtl/ahp_result_latch.sv
module ahp_result_latch
  import ahp_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int LO_W   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  ahp_mode_e               mode,
  input  logic                    cs_a,
  input  logic                    rd_a,
  input  logic                    wide,
  input  logic                    byte_hi,
  input  logic                    accept,
  input  logic [DATA_W-1:0]       res,
  input  logic                    ovr,
  output logic [LO_W-1:0]         dout_lo,
  output logic [DATA_W-LO_W:0]    dout_hi,
  output logic                    oe_lo,
  output logic                    oe_hi,
  output logic                    frozen
);

  localparam int W = DATA_W + 1;

  logic         rd_now, rd_q, sel_q, rd_rise, rd_fall, fast_byte;
  logic         frozen_q, frozen_d, lat_en;
  logic [W-1:0] lat_q, lat_d;

  // Next-state
  always_comb begin
    rd_now    = cs_a & rd_a;
    rd_rise   = rd_now & ~rd_q;
    rd_fall   = ~rd_now & rd_q;
    fast_byte = (mode == AHP_FAST) & ~wide;
    frozen_d  = frozen_q;
    if (!fast_byte)                frozen_d = 1'b0;
    else if (rd_rise && byte_hi)   frozen_d = 1'b1;
    else if (rd_fall && !sel_q)    frozen_d = 1'b0;
    lat_en    = accept & ~frozen_q;
    lat_d     = {ovr, res};
    oe_lo     = rd_now & (wide | ~byte_hi);
    oe_hi     = rd_now & (wide | byte_hi);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q     <= 1'b0;
      sel_q    <= 1'b0;
      frozen_q <= 1'b0;
    end else begin
      rd_q     <= rd_now;
      sel_q    <= byte_hi;
      frozen_q <= frozen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (lat_en) lat_q <= lat_d;
  end

  assign dout_lo = lat_q[LO_W-1:0];
  assign dout_hi = lat_q[W-1:LO_W];
  assign frozen  = frozen_q;

  AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_q |=> $stable(lat_q)); // R6
  AST_FREEZE_FAST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen_q && (mode != AHP_FAST)) |=> !frozen_q); // R6
  AST_BYTE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |-> $onehot0({oe_hi, oe_lo})); // R4

endmodule

// File: rtl/adc_host_port.sv
module adc_host_port
  import ahp_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int LO_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              slow_strap,
  input  logic              wide_bus,
  input  logic              byte_hi,
  output logic              conv_start,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              conv_ovr,
  output logic              busy,
  output logic              busy_oe,
  output logic [DATA_W:0]   dout,
  output logic              oe_lo,
  output logic              oe_hi
);

  localparam int NSYNC = 6;
  localparam int HI_W  = DATA_W + 1 - LO_W;

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_int_n, rst_meta_q} <= 2'b00;
    else        {rst_int_n, rst_meta_q} <= {rst_meta_q, 1'b1};
  end

  logic [NSYNC-1:0] sync_q;
  ahp_sync #(
    .WIDTH  (NSYNC),
    .STAGES (SYNC_STAGES),
    .RST_VAL(6'b000111)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d    ({byte_hi, wide_bus, slow_strap, rd_n, wr_n, cs_n}),
    .q    (sync_q)
  );

  logic      cs_a, wr_a, rd_a, slow_s, wide_s, bhi_s, active, accept, frozen;
  ahp_mode_e mode;
  logic [LO_W-1:0] dout_lo;
  logic [HI_W-1:0] dout_hi;

  assign cs_a   = ~sync_q[0];
  assign wr_a   = ~sync_q[1];
  assign rd_a   = ~sync_q[2];
  assign slow_s = sync_q[3];
  assign wide_s = sync_q[4];
  assign bhi_s  = sync_q[5];
  assign mode   = ahp_decode(slow_s, cs_a, rd_a, wr_a);
  assign accept = conv_done & active;

  ahp_conv_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .mode      (mode),
    .cs_a      (cs_a),
    .wr_a      (wr_a),
    .rd_a      (rd_a),
    .conv_done (conv_done),
    .conv_start(conv_start),
    .active    (active),
    .busy_val  (busy),
    .busy_oe   (busy_oe)
  );

  ahp_result_latch #(
    .DATA_W(DATA_W),
    .LO_W  (LO_W)
  ) u_latch (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .mode   (mode),
    .cs_a   (cs_a),
    .rd_a   (rd_a),
    .wide   (wide_s),
    .byte_hi(bhi_s),
    .accept (accept),
    .res    (conv_data),
    .ovr    (conv_ovr),
    .dout_lo(dout_lo),
    .dout_hi(dout_hi),
    .oe_lo  (oe_lo),
    .oe_hi  (oe_hi),
    .frozen (frozen)
  );

  assign dout = {dout_hi, dout_lo};

  AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_int_n)
    (conv_done && !active) |=> $stable(dout)); // R10
  AST_FROZEN_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (frozen && accept) |=> $stable(dout)); // R6

endmodule

// File: tb/adc_host_port_tb_top.sv
`timescale 1ns/1ps
module adc_host_port_tb_top;

  localparam int DW  = 10;
  localparam int LAT = 4;

  logic clk = 1'b0;
  logic rst_n, cs_n, wr_n, rd_n, slow_strap, wide_bus, byte_hi;
  logic conv_start, conv_done, conv_ovr, busy, busy_oe, oe_lo, oe_hi;
  logic [DW-1:0] conv_data, eng_data, spur_data;
  logic [DW:0]   dout, last_res;
  logic eng_done, eng_ovr, spur_done, ovr_next;
  logic [DW-1:0] res_base = 10'h155;
  int total = 0, bad = 0, ncv = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  assign conv_done = eng_done | spur_done;
  assign conv_data = spur_done ? spur_data : eng_data;
  assign conv_ovr  = spur_done ? 1'b0 : eng_ovr;

  adc_host_port dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .slow_strap(slow_strap), .wide_bus(wide_bus), .byte_hi(byte_hi),
    .conv_start(conv_start), .conv_done(conv_done), .conv_data(conv_data),
    .conv_ovr(conv_ovr), .busy(busy), .busy_oe(busy_oe), .dout(dout),
    .oe_lo(oe_lo), .oe_hi(oe_hi)
  );

  // Conversion engine model: done LAT-1 cycles after a start is seen.
  initial begin
    eng_done = 1'b0; eng_data = '0; eng_ovr = 1'b0;
    forever begin
      @(negedge clk);
      eng_done = 1'b0;
      if (conv_start === 1'b1) begin
        ncv++;
        repeat (LAT-1) @(negedge clk);
        eng_data = res_base + 10'(ncv);
        eng_ovr  = ovr_next;
        last_res = {ovr_next, eng_data};
        eng_done = 1'b1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_bus();
    cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    wait_cyc(12);
  endtask

  task automatic wait_done_edge();
    do @(posedge clk); while (conv_done !== 1'b1);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R11 conv_start", conv_start, 0);
    check("R11 busy_oe", busy_oe, 0);
    check("R11 oe_lo", oe_lo, 0);
    check("R11 oe_hi", oe_hi, 0);
    check("R11 dout", dout, 0);
  endtask

  task automatic t_slow_single();
    int n0;
    slow_strap = 1'b1; wide_bus = 1'b1; wait_cyc(4);
    n0 = ncv;
    cs_n = 1'b0; wr_n = 1'b0;
    @(negedge clk); check("R1 start not before 2 cycles", conv_start, 0);
    @(negedge clk); check("R1 start at 2 cycles", conv_start, 1);
    check("R2 busy before start edge", busy, 1);
    check("R2 busy_oe with cs low", busy_oe, 1);
    @(negedge clk); check("R2 busy low in conversion", busy, 0);
    wr_n = 1'b1;
    wait_cyc(10);
    check("R1 one conversion per pulse", ncv - n0, 1);
    check("R2 busy high after done", busy, 1);
    rd_n = 1'b0; wait_cyc(3);
    check("R3 oe_lo wide", oe_lo, 1);
    check("R3 oe_hi wide", oe_hi, 1);
    check("R3 dout word", dout, last_res);
    rd_n = 1'b1; cs_n = 1'b1; wait_cyc(3);
    check("R2 busy_oe released", busy_oe, 0);
    check("R4 no enables rd high", {oe_hi, oe_lo}, 0);
    idle_bus();
  endtask

  task automatic t_cs_gate();
    int n0;
    slow_strap = 1'b1; n0 = ncv;
    cs_n = 1'b1; wr_n = 1'b0; wait_cyc(3);
    wr_n = 1'b1; wait_cyc(10);
    check("R1 no start with cs high", ncv - n0, 0);
    idle_bus();
  endtask

  task automatic t_byte_sel();
    slow_strap = 1'b1; wide_bus = 1'b0; byte_hi = 1'b1;
    cs_n = 1'b0; rd_n = 1'b0; wait_cyc(3);
    check("R4 high byte enables", {oe_hi, oe_lo}, 2'b10);
    byte_hi = 1'b0; wait_cyc(3);
    check("R4 low byte enables", {oe_hi, oe_lo}, 2'b01);
    rd_n = 1'b1; wait_cyc(3);
    check("R4 rd high no enables", {oe_hi, oe_lo}, 2'b00);
    check("R2 busy_oe cs low", busy_oe, 1);
    cs_n = 1'b1; wait_cyc(3);
    check("R2 busy_oe both high", busy_oe, 0);
    idle_bus();
  endtask

  task automatic t_fast_cont();
    int n0;
    slow_strap = 1'b0; wide_bus = 1'b1; cs_n = 1'b1; rd_n = 1'b1;
    n0 = ncv; wr_n = 1'b0; wait_cyc(40);
    check("R5 continuous without cs", (ncv - n0) >= 5, 1);
    rd_n = 1'b0; wait_cyc(3);
    check("R5 cs high blocks read", {oe_hi, oe_lo}, 2'b00);
    idle_bus();
  endtask

  task automatic t_fast_freeze();
    logic [DW:0] v;
    int n0;
    slow_strap = 1'b0; wide_bus = 1'b0; byte_hi = 1'b1;
    cs_n = 1'b0; wr_n = 1'b0; wait_cyc(12);
    rd_n = 1'b0; wait_cyc(3);
    v = dout; n0 = ncv;
    check("R6 high byte enabled", {oe_hi, oe_lo}, 2'b10);
    check("R7 busy low during fast read", busy, 0);
    wait_cyc(20);
    check("R6 conversions continue", (ncv - n0) >= 3, 1);
    check("R6 frozen during high read", dout, v);
    rd_n = 1'b1; wait_cyc(8);
    check("R6 frozen between bytes", dout, v);
    byte_hi = 1'b0; rd_n = 1'b0; wait_cyc(3);
    check("R6 low byte enabled", {oe_hi, oe_lo}, 2'b01);
    check("R6 frozen at low read", dout, v);
    wait_cyc(10);
    check("R6 frozen through low read", dout, v);
    rd_n = 1'b1; wait_cyc(10);
    wr_n = 1'b1; wait_cyc(12);
    check("R6 updates resume", dout, last_res);
    check("R6 frozen value left", dout != v, 1);
    idle_bus();
  endtask

  task automatic t_fast_refresh();
    slow_strap = 1'b0; wide_bus = 1'b1;
    cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0; wait_cyc(6);
    for (int k = 0; k < 3; k++) begin
      wait_done_edge();
      check("R8 refresh while reading", dout, last_res);
      check("R3 both enables", {oe_hi, oe_lo}, 2'b11);
    end
    idle_bus();
  endtask

  task automatic t_dma();
    int n0;
    slow_strap = 1'b1; wide_bus = 1'b0; byte_hi = 1'b0;
    n0 = ncv;
    cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0; wait_cyc(30);
    check("R7 hardwired continuous", (ncv - n0) >= 4, 1);
    check("R7 busy low", busy, 0);
    check("R7 busy driven", busy_oe, 1);
    for (int k = 0; k < 2; k++) begin
      wait_done_edge();
      check("R9 low byte first refresh", dout, last_res);
      check("R9 low byte enable", oe_lo, 1);
    end
    byte_hi = 1'b1; wait_cyc(3);
    for (int k = 0; k < 2; k++) begin
      wait_done_edge();
      check("R9 high byte no freeze", dout, last_res);
      check("R9 high byte enable", oe_hi, 1);
    end
    idle_bus();
  endtask

  task automatic t_slow_byte_order();
    slow_strap = 1'b1; wide_bus = 1'b0; byte_hi = 1'b1; ovr_next = 1'b1;
    cs_n = 1'b0; rd_n = 1'b0; wait_cyc(3);
    rd_n = 1'b1; wait_cyc(3);
    wr_n = 1'b0; wait_cyc(3);
    wr_n = 1'b1; wait_cyc(12);
    rd_n = 1'b0; wait_cyc(3);
    check("R9 slow high read does not freeze", dout, last_res);
    check("R3 flag in top bit", dout[DW], 1);
    rd_n = 1'b1; ovr_next = 1'b0;
    idle_bus();
  endtask

  task automatic t_spurious();
    logic [DW:0] v;
    int n0;
    slow_strap = 1'b1; wide_bus = 1'b1;
    cs_n = 1'b0; rd_n = 1'b0; wait_cyc(3);
    v = dout; n0 = ncv;
    @(negedge clk); #1; spur_data = ~v[DW-1:0]; spur_done = 1'b1;
    @(negedge clk); #1; spur_done = 1'b0;
    wait_cyc(3);
    check("R10 idle done ignored dout", dout, v);
    check("R10 idle done busy", busy, 1);
    check("R10 no conversion", ncv - n0, 0);
    idle_bus();
  endtask

  initial begin
    cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    slow_strap = 1'b1; wide_bus = 1'b1; byte_hi = 1'b0;
    ovr_next = 1'b0; spur_done = 1'b0; spur_data = '0; last_res = '0;
    rst_n = 1'b0;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(8);
    t_reset();
    t_slow_single();
    t_cs_gate();
    t_byte_sel();
    t_fast_cont();
    t_fast_freeze();
    t_fast_refresh();
    t_dma();
    t_slow_byte_order();
    t_spurious();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule